// File: doc/BRIEF.md
# Address-Error Exception Frame Sequencer

This block runs the bus side of entry into an address-error exception. When the core raises `start`, the block captures the faulting access: its address, its read/write and instruction/data attributes and its 3-bit function code. It also captures the current instruction register, status register, program counter and supervisor stack pointer. It waits a fixed number of idle cycles, then pushes a seven-word frame onto the supervisor stack in a fixed, non-sequential address order. Next it reads the handler address from a fixed low vector location and refills the two-word prefetch queue from that handler address.

The bus is a simple word-wide request/acknowledge port. A cycle is presented on `bus_req` together with its address, direction, write data and function code. It completes in the cycle in which `bus_ack` is high. The core takes the new status register, stack pointer, program counter and prefetch words from the block's outputs once `done` pulses.

Top module: `addr_err_seq`

## Requirements
- R1: While reset is applied, and after it is released with no `start`, `bus_req`, `busy` and `done` are 0 and `pc_out`, `ssp_out` and `sr_out` are 0. Reset applied in the middle of a sequence drops `bus_req` and `busy` at once. A `bus_ack` pulse while idle starts nothing and changes no output.
- R2: After `start` is sampled, `bus_req` stays low for exactly 4 clock cycles. The first request appears in the 5th cycle.
- R3: Seven word write cycles follow back to back, with `bus_we`=1 and `bus_fc`=5. With S the captured stack pointer, their addresses and data in order are: S-2 ← PC[15:0], S-6 ← SR, S-4 ← PC[31:16], S-8 ← IR, S-10 ← fault address[15:0], S-14 ← status word, S-12 ← fault address[31:16].
- R4: The status word is {IR[15:5], rd, ins, fc}. Bit 4 is 1 for a faulting read, bit 3 is 1 for an instruction access, and bits 2..0 are the faulting function code.
- R5: `ssp_out` equals the captured stack pointer minus 14, modulo 2^32.
- R6: After the frame, two read cycles with `bus_fc`=5 fetch the vector: address 12 gives the high word and address 14 gives the low word. `pc_out` then equals {high, low}.
- R7: Two read cycles with `bus_fc`=6 then fetch the prefetch words at the new PC and at the new PC+2, modulo 2^32. Exactly 2 idle cycles separate them. All other cycles from the first write to the first prefetch read run back to back.
- R8: A request that is not acknowledged is held with unchanged address, direction, write data and function code until `bus_ack` is seen.
- R9: The SR value written to the stack is the value captured at `start`. `sr_out` is that value with bit 13 (supervisor) set and bit 15 (trace) cleared.
- R10: `done` is a one-cycle pulse in the cycle after the second prefetch word is acknowledged, and `busy` is high from the cycle after `start` until then. A `start` or a change of inputs while busy has no effect on the sequence.
- R11: `pf0_out` and `pf1_out` hold the words read by the first and the second prefetch cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Address-error request, sampled when idle |
| flt_addr | input | 32 | Faulting access address |
| flt_read | input | 1 | Faulting access was a read |
| flt_instr | input | 1 | Faulting access was an instruction access |
| flt_fc | input | 3 | Function code of the faulting access |
| ir_in | input | 16 | Current instruction register |
| sr_in | input | 16 | Current status register |
| pc_in | input | 32 | Current program counter |
| ssp_in | input | 32 | Current supervisor stack pointer |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_fc | output | 3 | Function code of the cycle |
| bus_ack | input | 1 | Cycle completes in this clock |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | New status register |
| ssp_out | output | 32 | New supervisor stack pointer |
| pc_out | output | 32 | New program counter (handler address) |
| pf0_out | output | 16 | First prefetch word |
| pf1_out | output | 16 | Second prefetch word |

## Verification
The hardest situation to reach is a request that stalls. The design must hold every bus field while acknowledge is withheld, and it must also keep the two-cycle gap before the last prefetch, which must not collapse or stretch with the wait count. The bench memory model inserts a per-case number of wait states, zero to three. It records the first-request and acknowledge cycle of each transaction and compares every held cycle against the first one. A second `start` with scrambled inputs is pulsed in the middle of each sequence, so capture-only-at-entry is seen at the bus. The vector and stack values are chosen so that the PC+2 address and the stack pointer wrap at 32 bits.

// File: rtl/addr_err_seq.sv
module addr_err_seq #(
  parameter int          IDLE_PRE = 4,
  parameter int          IDLE_GAP = 2,
  parameter logic [31:0] VEC_ADDR = 32'd12,
  parameter logic [2:0]  FC_DATA  = 3'd5,
  parameter logic [2:0]  FC_PROG  = 3'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] flt_addr,
  input  logic        flt_read,
  input  logic        flt_instr,
  input  logic [2:0]  flt_fc,
  input  logic [15:0] ir_in,
  input  logic [15:0] sr_in,
  input  logic [31:0] pc_in,
  input  logic [31:0] ssp_in,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [15:0] bus_wdata,
  output logic [2:0]  bus_fc,
  input  logic        bus_ack,
  input  logic [15:0] bus_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] sr_out,
  output logic [31:0] ssp_out,
  output logic [31:0] pc_out,
  output logic [15:0] pf0_out,
  output logic [15:0] pf1_out
);

  localparam int          FRAME_BYTES = 14;
  localparam int          CW          = $clog2(IDLE_PRE + IDLE_GAP + 1);
  localparam logic [3:0]  ST_VHI      = 4'd7;
  localparam logic [3:0]  ST_VLO      = 4'd8;
  localparam logic [3:0]  ST_PF0      = 4'd9;
  localparam logic [3:0]  ST_PF1      = 4'd10;
  localparam logic [15:0] SR_S        = 16'h2000;
  localparam logic [15:0] SR_T        = 16'h8000;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BUS, S_GAP} state_t;

  state_t         state;
  logic [3:0]     step;
  logic [CW-1:0]  cnt;
  logic [15:0]    ir_q, sr_q, stat_q;
  logic [31:0]    pc_q, sp_q, fa_q, vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= '0;
      cnt     <= '0;
      ir_q    <= '0;
      sr_q    <= '0;
      stat_q  <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      fa_q    <= '0;
      vec_q   <= '0;
      done    <= 1'b0;
      sr_out  <= '0;
      ssp_out <= '0;
      pc_out  <= '0;
      pf0_out <= '0;
      pf1_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_PRE;
          cnt     <= '0;
          step    <= '0;
          ir_q    <= ir_in;
          sr_q    <= sr_in;
          pc_q    <= pc_in;
          sp_q    <= ssp_in;
          fa_q    <= flt_addr;
          stat_q  <= {ir_in[15:5], flt_read, flt_instr, flt_fc};
          sr_out  <= (sr_in | SR_S) & ~SR_T;
          ssp_out <= ssp_in - 32'(FRAME_BYTES);
        end
        S_PRE: begin
          if (cnt == CW'(IDLE_PRE - 1)) state <= S_BUS;
          else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt == CW'(IDLE_GAP - 1)) state <= S_BUS;
          else cnt <= cnt + 1'b1;
        end
        S_BUS: if (bus_ack) begin
          case (step)
            ST_VHI: begin
              vec_q[31:16] <= bus_rdata;
              step         <= step + 1'b1;
            end
            ST_VLO: begin
              vec_q[15:0] <= bus_rdata;
              pc_out      <= {vec_q[31:16], bus_rdata};
              step        <= step + 1'b1;
            end
            ST_PF0: begin
              pf0_out <= bus_rdata;
              state   <= S_GAP;
              cnt     <= '0;
              step    <= ST_PF1;
            end
            ST_PF1: begin
              pf1_out <= bus_rdata;
              state   <= S_IDLE;
              done    <= 1'b1;
            end
            default: step <= step + 1'b1;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign bus_req = (state == S_BUS);
  assign bus_we  = (step < ST_VHI);
  assign bus_fc  = (step >= ST_PF0) ? FC_PROG : FC_DATA;

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (step)
      4'd0:    begin bus_addr = sp_q - 32'd2;  bus_wdata = pc_q[15:0];  end
      4'd1:    begin bus_addr = sp_q - 32'd6;  bus_wdata = sr_q;        end
      4'd2:    begin bus_addr = sp_q - 32'd4;  bus_wdata = pc_q[31:16]; end
      4'd3:    begin bus_addr = sp_q - 32'd8;  bus_wdata = ir_q;        end
      4'd4:    begin bus_addr = sp_q - 32'd10; bus_wdata = fa_q[15:0];  end
      4'd5:    begin bus_addr = sp_q - 32'd14; bus_wdata = stat_q;      end
      4'd6:    begin bus_addr = sp_q - 32'd12; bus_wdata = fa_q[31:16]; end
      ST_VHI:  bus_addr = VEC_ADDR;
      ST_VLO:  bus_addr = VEC_ADDR + 32'd2;
      ST_PF0:  bus_addr = vec_q;
      ST_PF1:  bus_addr = vec_q + 32'd2;
      default: bus_addr = '0;
    endcase
  end

endmodule

// File: rtl/addr_err_seq_chk.sv
module addr_err_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic [2:0]  bus_fc,
  input logic        busy,
  input logic        done,
  input logic [15:0] sr_out
);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata) && $stable(bus_fc));

  assert_write_fc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_fc == 3'd5);

  assert_prog_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_fc == 3'd6 |-> !bus_we);

  assert_quiet_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !bus_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req && !busy);

  assert_req_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_sr_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> sr_out[13] && !sr_out[15]);

endmodule

bind addr_err_seq addr_err_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_fc(bus_fc), .busy(busy), .done(done), .sr_out(sr_out)
);

// File: tb/test_addr_err_seq.sv
module test_addr_err_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        flt_read = 1'b0, flt_instr = 1'b0;
  logic [2:0]  flt_fc = '0;
  logic [15:0] ir_in = '0, sr_in = '0;
  logic [31:0] pc_in = '0, ssp_in = '0;
  logic        bus_req, bus_we, busy, done;
  logic [31:0] bus_addr, ssp_out, pc_out;
  logic [15:0] bus_wdata, sr_out, pf0_out, pf1_out;
  logic [2:0]  bus_fc;
  logic        ack_m = 1'b0, ack_junk = 1'b0;
  logic        bus_ack;
  logic [15:0] bus_rdata = '0;

  assign bus_ack = ack_m | ack_junk;

  always #4 clk = ~clk;

  addr_err_seq i_addr_err_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .flt_addr(flt_addr),
    .flt_read(flt_read), .flt_instr(flt_instr), .flt_fc(flt_fc),
    .ir_in(ir_in), .sr_in(sr_in), .pc_in(pc_in), .ssp_in(ssp_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_fc(bus_fc), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .sr_out(sr_out),
    .ssp_out(ssp_out), .pc_out(pc_out), .pf0_out(pf0_out), .pf1_out(pf1_out)
  );

  typedef struct packed {
    logic [15:0] ir;
    logic [15:0] sr;
    logic [31:0] pc;
    logic [31:0] ssp;
    logic [31:0] fa;
    logic        rd;
    logic        ins;
    logic [2:0]  fc;
    logic [31:0] vec;
    logic [1:0]  wt;
  } case_t;

  localparam int NC = 4;
  localparam case_t CASES [NC] = '{
    '{16'hB74C, 16'h2701, 32'h0000_0C00, 32'h0000_0800, 32'h35AA_67B7, 1'b1, 1'b0, 3'd5, 32'h0000_1400, 2'd0},
    '{16'h4E71, 16'hA700, 32'h0001_2346, 32'h0000_3000, 32'h0001_2347, 1'b0, 1'b1, 3'd6, 32'h0002_0000, 2'd1},
    '{16'hFFFF, 16'h0015, 32'hFFFF_FFFE, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 3'd1, 32'h00FF_FFF0, 2'd3},
    '{16'h0000, 16'h8000, 32'h0000_0000, 32'h0000_0006, 32'h0000_0001, 1'b0, 1'b0, 3'd2, 32'hFFFF_FFFE, 2'd2}
  };

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] cur_vec = '0;
  logic [1:0]  cur_wt = '0;
  int          n_tr = 0, hold_err = 0, waitc = 0;
  logic        infl = 1'b0;
  logic [31:0] h_addr;
  logic [15:0] h_wdata;
  logic        h_we;
  logic [2:0]  h_fc;
  logic [31:0] t_addr [16];
  logic [15:0] t_data [16];
  logic        t_we [16];
  logic [2:0]  t_fc [16];
  int          t_first [16];
  int          t_ack [16];
  int          cur_first = 0;

  function automatic logic [15:0] mem_word(logic [31:0] a);
    if (a == 32'd12)      return cur_vec[31:16];
    else if (a == 32'd14) return cur_vec[15:0];
    else                  return a[15:0] ^ 16'hA5C3;
  endfunction

  always @(negedge clk) begin
    if (ack_m) ack_m = 1'b0;
    if (rst_n && bus_req) begin
      if (!infl) begin
        infl = 1'b1; waitc = 0; cur_first = cyc;
        h_addr = bus_addr; h_wdata = bus_wdata; h_we = bus_we; h_fc = bus_fc;
      end else if (bus_addr != h_addr || bus_wdata != h_wdata ||
                   bus_we != h_we || bus_fc != h_fc) begin
        hold_err = hold_err + 1;
      end
      if (waitc == int'(cur_wt)) begin
        ack_m = 1'b1;
        bus_rdata = mem_word(bus_addr);
        if (n_tr < 16) begin
          t_addr[n_tr] = bus_addr; t_data[n_tr] = bus_wdata;
          t_we[n_tr] = bus_we; t_fc[n_tr] = bus_fc;
          t_first[n_tr] = cur_first; t_ack[n_tr] = cyc;
        end
        n_tr = n_tr + 1;
        infl = 1'b0;
      end else begin
        waitc = waitc + 1;
      end
    end else begin
      infl = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_case(input case_t c, input int idx);
    logic [31:0] ea [11];
    logic [15:0] ed [11];
    logic [15:0] st;
    int k0, dcyc, b2b_bad;
    bit dn;
    st = {c.ir[15:5], c.rd, c.ins, c.fc};
    ea[0] = c.ssp - 32'd2;  ed[0] = c.pc[15:0];
    ea[1] = c.ssp - 32'd6;  ed[1] = c.sr;
    ea[2] = c.ssp - 32'd4;  ed[2] = c.pc[31:16];
    ea[3] = c.ssp - 32'd8;  ed[3] = c.ir;
    ea[4] = c.ssp - 32'd10; ed[4] = c.fa[15:0];
    ea[5] = c.ssp - 32'd14; ed[5] = st;
    ea[6] = c.ssp - 32'd12; ed[6] = c.fa[31:16];
    ea[7] = 32'd12;  ea[8] = 32'd14;
    ea[9] = c.vec;   ea[10] = c.vec + 32'd2;
    for (int i = 7; i < 11; i++) ed[i] = 16'h0000;

    @(negedge clk);
    cur_vec = c.vec; cur_wt = c.wt; n_tr = 0; hold_err = 0;
    ir_in = c.ir; sr_in = c.sr; pc_in = c.pc; ssp_in = c.ssp;
    flt_addr = c.fa; flt_read = c.rd; flt_instr = c.ins; flt_fc = c.fc;
    start = 1'b1; k0 = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", 64'(busy), 64'd1);
    repeat (10) @(negedge clk);
    // R10: scrambled inputs and a second start while busy
    ir_in = ~c.ir; sr_in = ~c.sr; pc_in = ~c.pc; ssp_in = ~c.ssp;
    flt_addr = ~c.fa; flt_read = ~c.rd; flt_instr = ~c.ins; flt_fc = ~c.fc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 1'b0; dcyc = 0;
    for (int w = 0; w < 400 && !dn; w++) begin
      @(negedge clk);
      if (done) begin dn = 1'b1; dcyc = cyc; end
    end
    repeat (3) @(negedge clk);
    check(dn, "R10", $sformatf("case %0d done seen", idx), 64'(dn), 64'd1);
    check(n_tr == 11, "R3", $sformatf("case %0d transaction count", idx), 64'(n_tr), 64'd11);
    if (n_tr == 11) begin
      for (int i = 0; i < 11; i++) begin
        bit ok;
        ok = (t_addr[i] == ea[i]) && (t_we[i] == (i < 7)) &&
             (t_fc[i] == ((i >= 9) ? 3'd6 : 3'd5)) &&
             ((i >= 7) || (t_data[i] == ed[i]));
        check(ok, (i < 7) ? ((i == 5) ? "R4" : "R3") : ((i < 9) ? "R6" : "R7"),
              $sformatf("case %0d tr %0d addr/we/fc/data", idx, i),
              {t_addr[i], t_data[i], 12'h0, t_we[i], t_fc[i]},
              {ea[i], ed[i], 12'h0, 1'(i < 7), ((i >= 9) ? 3'd6 : 3'd5)});
      end
      check(t_first[0] == k0 + 5, "R2", $sformatf("case %0d first request cycle", idx),
            64'(t_first[0]), 64'(k0 + 5));
      b2b_bad = 0;
      for (int i = 1; i < 10; i++) if (t_first[i] != t_ack[i-1] + 1) b2b_bad++;
      check(b2b_bad == 0, "R7", $sformatf("case %0d back-to-back cycles", idx),
            64'(b2b_bad), 64'd0);
      check(t_first[10] == t_ack[9] + 3, "R7", $sformatf("case %0d prefetch gap", idx),
            64'(t_first[10] - t_ack[9] - 1), 64'd2);
      check(dcyc == t_ack[10] + 1, "R10", $sformatf("case %0d done cycle", idx),
            64'(dcyc), 64'(t_ack[10] + 1));
    end
    check(hold_err == 0, "R8", $sformatf("case %0d held request stable", idx),
          64'(hold_err), 64'd0);
    check(ssp_out == c.ssp - 32'd14, "R5", $sformatf("case %0d ssp", idx),
          64'(ssp_out), 64'(c.ssp - 32'd14));
    check(pc_out == c.vec, "R6", $sformatf("case %0d pc", idx), 64'(pc_out), 64'(c.vec));
    check(sr_out == ((c.sr | 16'h2000) & 16'h7FFF), "R9", $sformatf("case %0d sr", idx),
          64'(sr_out), 64'((c.sr | 16'h2000) & 16'h7FFF));
    check(pf0_out == (c.vec[15:0] ^ 16'hA5C3), "R11", $sformatf("case %0d pf0", idx),
          64'(pf0_out), 64'(c.vec[15:0] ^ 16'hA5C3));
    check(pf1_out == ((c.vec[15:0] + 16'd2) ^ 16'hA5C3), "R11", $sformatf("case %0d pf1", idx),
          64'(pf1_out), 64'((c.vec[15:0] + 16'd2) ^ 16'hA5C3));
    check(!busy && !bus_req && !done, "R10", $sformatf("case %0d idle after", idx),
          {61'h0, busy, bus_req, done}, 64'd0);
  endtask

  initial begin
    logic [31:0] pc_prev;
    repeat (3) @(negedge clk);
    check(!bus_req && !busy && !done, "R1", "outputs in reset",
          {61'h0, bus_req, busy, done}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_req && !busy && !done, "R1", "idle after reset",
          {61'h0, bus_req, busy, done}, 64'd0);
    check(pc_out == 0 && ssp_out == 0 && sr_out == 0, "R1", "state outputs after reset",
          {pc_out, ssp_out}, 64'd0);

    pc_prev = pc_out;
    ack_junk = 1'b1;
    repeat (3) @(negedge clk);
    ack_junk = 1'b0;
    @(negedge clk);
    check(!bus_req && !busy && pc_out == pc_prev, "R1", "stray ack while idle",
          {30'h0, bus_req, busy, pc_out}, {32'h0, pc_prev});

    for (int i = 0; i < NC; i++) run_case(CASES[i], i);

    @(negedge clk);
    cur_vec = 32'h0000_4000; cur_wt = 2'd0;
    ssp_in = 32'h0000_1000; pc_in = 32'h100; ir_in = 16'h1234; sr_in = 16'h2700;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!bus_req && !busy, "R1", "reset mid-sequence", {62'h0, bus_req, busy}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_req && !busy && !done, "R1", "quiet after mid reset",
          {61'h0, bus_req, busy, done}, 64'd0);

    run_case(CASES[0], 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule